// File: doc/BRIEF.md
# Double-Buffered Nine-Bit Serial Transmitter

This block is the transmit half of an asynchronous serial port. The host writes a byte with a single-cycle strobe. The block places the byte in a one-entry holding register. From there it moves into a shift register and goes out on the serial line, least significant bit first, framed by a low start bit and a high stop bit. Each bit lasts exactly one period of an external baud tick. A frame-mode input selects 8 or 9 data bits. The ninth bit comes from a small register that the host loads through its own strobe.

Double buffering can be switched on or off. When it is on, the host can queue the next character while the current one is still shifting. Consecutive characters then leave the line separated by a single stop bit. The interrupt flag rises as soon as the holding register has room again, and the ninth bit is captured together with the byte. When it is off, the block behaves like a plain single-buffer transmitter. The interrupt flag marks the end of the frame, and the ninth bit is read only when its slot is shifted out. The synchronous frame-mode code always runs with double buffering off. A write that finds no room is dropped and sets a sticky overrun bit.

Top module: `uart9_dbtx`

## Requirements
- R1: After reset the serial line is high, the interrupt flag is 0, the overrun bit is 0 and no character is pending or in flight.
- R2: A frame is one low start bit, the data bits LSB first, the ninth bit when it is enabled, and one high stop bit. Every bit holds for one baud-tick period, and the line changes only on a clock edge where the baud tick is high.
- R3: The frame-mode encoding is 2'b01 for 8 data bits and 2'b10 or 2'b11 for 9 data bits. 2'b00 is the synchronous-mode code, which this block sends with the 8-bit layout.
- R4: A character written to an empty holding register moves into the shift register at the next baud tick if the shifter is idle. Otherwise it moves at the tick that ends the stop bit. With double buffering on, a write is accepted while a frame is shifting.
- R5: A character that is waiting when a frame's stop bit ends starts its start bit on that same tick, so exactly one stop bit separates the two frames.
- R6: With double buffering on, the interrupt flag is set on the tick where the holding register hands its character to the shift register.
- R7: With double buffering off, the interrupt flag is set on the tick that ends the stop bit, and not earlier. A byte write made while a character is pending or shifting is ignored.
- R8: With double buffering on, the ninth bit sent is the ninth-bit register value at the time of the byte write. Later changes to that register do not affect the frame.
- R9: With double buffering off, the ninth bit sent is the ninth-bit register value at the tick that shifts out the ninth-bit slot, even if the register was written after the byte.
- R10: A byte write that is not accepted leaves the stored character unchanged, sends nothing extra, and sets the overrun bit. The overrun bit stays at 1 until reset.
- R11: The interrupt flag stays set until the host pulses the clear input. The pulse clears it on the next clock edge.
- R12: With frame mode 2'b00 the double-buffer enable is treated as 0, so the interrupt flag and write acceptance follow R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse, one per bit period |
| frame_mode | input | 2 | Frame layout select (see R3) |
| dbuf_en | input | 1 | Double-buffer enable |
| wr_data | input | 1 | Byte write strobe |
| data_in | input | 8 | Byte to send |
| bit9_wr | input | 1 | Ninth-bit register write strobe |
| bit9_in | input | 1 | Value for the ninth-bit register |
| irq_clr | input | 1 | Clears the interrupt flag |
| txd | output | 1 | Serial line, idles high |
| tx_irq | output | 1 | Transmit interrupt flag |
| overrun | output | 1 | Sticky dropped-write indicator |

## Verification
The hardest situation to reach is the seam between two frames. Here a queued character must replace the stop bit's successor on the exact tick that ends the frame, while a third write arrives against a full holding register. The stimulus writes the second byte a few ticks into the first frame and then writes a third byte at once. It changes the ninth-bit register between and after those writes. The monitor decodes every bit on the line and checks that the second start bit follows the first stop bit with no idle tick. It also checks that the third byte never appears. The single-buffer case is reached by rewriting the ninth-bit register in the middle of a frame.

// File: rtl/uart9_pkg.sv
// Shared frame-mode encoding and helpers for the nine-bit transmitter.
// Assumes the 2-bit mode code is decoded only here.
package uart9_pkg;

    typedef enum logic [1:0] {
        FM_SYNC  = 2'b00,
        FM_8BIT  = 2'b01,
        FM_9BIT  = 2'b10,
        FM_9BITB = 2'b11
    } frame_mode_e;

    // True when the mode carries a ninth data bit.
    function automatic logic mode_has_ninth(frame_mode_e m);
        return (m == FM_9BIT) || (m == FM_9BITB);
    endfunction

    // True when the mode permits the holding register to act as a second buffer.
    function automatic logic mode_allows_dbuf(frame_mode_e m);
        return m != FM_SYNC;
    endfunction

endpackage

// File: rtl/uart9_hold.sv
// Holding register in front of the shifter. It accepts a byte when it is
// empty and, in single-buffer operation, only when the shifter is idle.
// It latches the ninth-bit register with the byte, releases on load, and
// flags refused writes in a sticky overrun bit.
// Assumes load is asserted only while hold_full is set.
module uart9_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] data_in,
    input  logic              b9_reg,
    input  logic              dbuf_eff,
    input  logic              shift_busy,
    input  logic              load,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_b9,
    output logic              overrun
);

    logic accept;

    // Write is taken only if the register is free and, without double buffering, the line is idle.
    always_comb accept = wr_data && !hold_full && (dbuf_eff || !shift_busy);

    // Holding register fill and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
            hold_b9   <= 1'b0;
        end else if (accept) begin
            hold_full <= 1'b1;
            hold_data <= data_in;
            hold_b9   <= b9_reg;
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end

    // Sticky record of refused writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (wr_data && !accept)
            overrun <= 1'b1;
    end

endmodule

// File: rtl/uart9_shift.sv
// Frame sequencer and shift register. On a baud tick it loads from the
// holding register when idle or at the end of a stop bit. Otherwise it
// steps through start, data (LSB first), optional ninth bit and stop.
// Assumes baud_tick is a single-cycle pulse.
module uart9_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_b9,
    input  logic              nine_mode,
    input  logic              use_live,
    input  logic              live_b9,
    output logic              txd,
    output logic              busy,
    output logic              load,
    output logic              frame_done
);

    localparam int POS_W = $clog2(DATA_W + 3);
    localparam logic [POS_W-1:0] LAST_DATA = POS_W'(DATA_W);
    localparam logic [POS_W-1:0] NINTH_POS = POS_W'(DATA_W + 1);
    localparam logic [POS_W-1:0] STOP9_POS = POS_W'(DATA_W + 2);

    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  next_pos;
    logic [DATA_W-1:0] sreg_q;
    logic              nine_f;
    logic              live_f;
    logic              b9_f;
    logic              at_stop;

    // Position bookkeeping for the current frame.
    always_comb begin
        next_pos = pos_q + 1'b1;
        at_stop  = busy && (pos_q == (nine_f ? STOP9_POS : NINTH_POS));
    end

    // Load and end-of-frame events, both tied to a baud tick.
    always_comb begin
        load       = baud_tick && hold_full && (!busy || at_stop);
        frame_done = baud_tick && at_stop;
    end

    // Frame state and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            pos_q  <= '0;
            sreg_q <= '0;
            nine_f <= 1'b0;
            live_f <= 1'b0;
            b9_f   <= 1'b0;
            txd    <= 1'b1;
        end else if (load) begin
            busy   <= 1'b1;
            pos_q  <= '0;
            sreg_q <= hold_data;
            nine_f <= nine_mode;
            live_f <= use_live;
            b9_f   <= hold_b9;
            txd    <= 1'b0;
        end else if (frame_done) begin
            busy <= 1'b0;
            txd  <= 1'b1;
        end else if (baud_tick && busy) begin
            pos_q <= next_pos;
            if (next_pos <= LAST_DATA) begin
                txd    <= sreg_q[0];
                sreg_q <= sreg_q >> 1;
            end else if (next_pos == NINTH_POS && nine_f) begin
                txd <= live_f ? live_b9 : b9_f;
            end else begin
                txd <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart9_irq.sv
// Transmit interrupt flag: set by an event pulse, held until cleared.
// A set event takes priority over a clear in the same cycle.
module uart9_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic irq_clr,
    output logic tx_irq
);

    // Sticky flag with host clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_irq <= 1'b0;
        else if (set_evt)
            tx_irq <= 1'b1;
        else if (irq_clr)
            tx_irq <= 1'b0;
    end

endmodule

// File: rtl/uart9_dbtx.sv
// Top level of the double-buffered nine-bit serial transmitter. It holds
// the ninth-bit register, decodes the frame mode, and picks the interrupt
// event for the buffering in force.
// Assumes baud_tick comes from an external rate generator.
module uart9_dbtx
    import uart9_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [1:0]        frame_mode,
    input  logic              dbuf_en,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] data_in,
    input  logic              bit9_wr,
    input  logic              bit9_in,
    input  logic              irq_clr,
    output logic              txd,
    output logic              tx_irq,
    output logic              overrun
);

    frame_mode_e       mode;
    logic              dbuf_eff;
    logic              nine_mode;
    logic              b9_reg;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              hold_b9;
    logic              busy;
    logic              load;
    logic              frame_done;
    logic              irq_set;

    // Mode decode: the synchronous code forces single buffering.
    always_comb begin
        mode      = frame_mode_e'(frame_mode);
        dbuf_eff  = dbuf_en && mode_allows_dbuf(mode);
        nine_mode = mode_has_ninth(mode);
    end

    // Ninth-bit register written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            b9_reg <= 1'b0;
        else if (bit9_wr)
            b9_reg <= bit9_in;
    end

    // Interrupt source follows the buffering mode.
    always_comb irq_set = dbuf_eff ? load : frame_done;

    uart9_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data    (wr_data),
        .data_in    (data_in),
        .b9_reg     (b9_reg),
        .dbuf_eff   (dbuf_eff),
        .shift_busy (busy),
        .load       (load),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .hold_b9    (hold_b9),
        .overrun    (overrun)
    );

    uart9_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .hold_b9    (hold_b9),
        .nine_mode  (nine_mode),
        .use_live   (!dbuf_eff),
        .live_b9    (b9_reg),
        .txd        (txd),
        .busy       (busy),
        .load       (load),
        .frame_done (frame_done)
    );

    uart9_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (irq_set),
        .irq_clr (irq_clr),
        .tx_irq  (tx_irq)
    );

endmodule

// File: rtl/uart9_dbtx_chk.sv
// Port-level temporal checks for uart9_dbtx, bound to every instance.
module uart9_dbtx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic irq_clr,
    input logic txd,
    input logic tx_irq,
    input logic overrun
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (txd && !tx_irq && !overrun));

    // R2
    line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd));

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !irq_clr) |=> tx_irq);

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R6
    irq_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> !$rose(tx_irq));

endmodule

bind uart9_dbtx uart9_dbtx_chk u_chk (.*);

// File: tb/tb_uart9_dbtx.sv
module tb_uart9_dbtx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [1:0] frame_mode = 2'b01;
    logic       dbuf_en = 1'b0;
    logic       wr_data = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       bit9_wr = 1'b0;
    logic       bit9_in = 1'b0;
    logic       irq_clr = 1'b0;
    logic       txd;
    logic       tx_irq;
    logic       overrun;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    int cycles = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] d;
        logic       b9;
        logic       nine;
        logic       b2b;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    uart9_dbtx dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .frame_mode(frame_mode),
        .dbuf_en(dbuf_en), .wr_data(wr_data), .data_in(data_in), .bit9_wr(bit9_wr),
        .bit9_in(bit9_in), .irq_clr(irq_clr), .txd(txd), .tx_irq(tx_irq), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Baud tick generator and line monitor (scoreboard consumer).
    int   phase = 0;
    bit   in_fr = 0;
    int   nb = 0;
    int   idle_cnt = 0;
    logic [7:0] got = 8'h00;
    logic gb9 = 1'b0;
    exp_t cur;

    always @(negedge clk) begin
        if (!rst_n) begin
            phase = 0; baud_tick = 1'b0; in_fr = 0; idle_cnt = 0;
        end else begin
            if (baud_tick) begin
                tick_cnt++;
                if (!in_fr) begin
                    if (txd == 1'b0) begin
                        if (q.size() == 0) begin
                            chk(0, "R10 unexpected frame", 1, 0);
                            cur = '{8'h00, 1'b0, 1'b0, 1'b0, "none"};
                        end else begin
                            cur = q.pop_front();
                        end
                        if (cur.b2b) chk(idle_cnt == 0, {cur.tag, " R5 gap"}, idle_cnt, 0);
                        in_fr = 1; nb = 0;
                    end else begin
                        idle_cnt++;
                    end
                end else begin
                    nb++;
                    if (nb <= 8) got[nb-1] = txd;
                    else if (nb == 9 && cur.nine) gb9 = txd;
                    if (nb == (cur.nine ? 10 : 9)) begin
                        chk(txd == 1'b1, {cur.tag, " R2 stop"}, txd, 1);
                        chk(got == cur.d, {cur.tag, " R2 data"}, got, cur.d);
                        if (cur.nine) chk(gb9 == cur.b9, {cur.tag, " ninth"}, gb9, cur.b9);
                        in_fr = 0; idle_cnt = 0;
                    end
                end
            end
            phase = (phase + 1) % 4;
            baud_tick = (phase == 0);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_ticks(input int n);
        int target = tick_cnt + n;
        while (tick_cnt < target) @(negedge clk);
    endtask

    // Driver: write a byte, optionally pushing the expected frame.
    task automatic send(input logic [7:0] d, input bit push, input logic b9,
                        input logic nine, input logic b2b, input string tag);
        @(negedge clk);
        data_in = d; wr_data = 1'b1;
        if (push) q.push_back('{d, b9, nine, b2b, tag});
        @(negedge clk);
        wr_data = 1'b0;
    endtask

    task automatic set_b9(input logic v);
        @(negedge clk); bit9_in = v; bit9_wr = 1'b1;
        @(negedge clk); bit9_wr = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(tx_irq == 1'b0, "R1 irq", tx_irq, 0);
        chk(overrun == 1'b0, "R1 overrun", overrun, 0);
        wait_ticks(4);
        chk(txd == 1'b1, "R1 idle line", txd, 1);

        // 8-bit, double buffered: irq on transfer (R3, R4, R6)
        frame_mode = 2'b01; dbuf_en = 1'b1;
        send(8'hA5, 1, 1'b0, 1'b0, 1'b0, "R3 R4 8bit");
        wait_ticks(3);
        chk(tx_irq == 1'b1, "R6 irq on transfer", tx_irq, 1);
        wait_ticks(14);
        chk(q.size() == 0, "R4 frame sent", q.size(), 0);

        // 9-bit, double buffered: back-to-back, latched ninth bit, overrun
        clear_irq();
        chk(tx_irq == 1'b0, "R11 cleared", tx_irq, 0);
        frame_mode = 2'b10;
        set_b9(1'b1);
        send(8'h3C, 1, 1'b1, 1'b1, 1'b0, "R3 9bit");
        wait_ticks(3);
        clear_irq();
        set_b9(1'b0);
        send(8'hC3, 1, 1'b0, 1'b1, 1'b1, "R4 R5 R8");
        set_b9(1'b1);
        send(8'hFF, 0, 1'b0, 1'b0, 1'b0, "R10");
        @(negedge clk);
        chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
        chk(tx_irq == 1'b0, "R6 no irq while held", tx_irq, 0);
        wait_ticks(30);
        chk(tx_irq == 1'b1, "R6 irq after second transfer", tx_irq, 1);
        chk(q.size() == 0, "R10 frames done", q.size(), 0);
        chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);

        // 9-bit alt code, single buffered: live ninth bit, irq at frame end (R7, R9)
        clear_irq();
        frame_mode = 2'b11; dbuf_en = 1'b0;
        set_b9(1'b0);
        send(8'h5A, 1, 1'b1, 1'b1, 1'b0, "R9 live ninth");
        wait_ticks(3);
        set_b9(1'b1);
        send(8'h11, 0, 1'b0, 1'b0, 1'b0, "R7");
        wait_ticks(2);
        chk(tx_irq == 1'b0, "R7 no irq mid frame", tx_irq, 0);
        wait_ticks(12);
        chk(tx_irq == 1'b1, "R7 irq at frame end", tx_irq, 1);
        wait_ticks(4);
        chk(q.size() == 0, "R7 ignored write", q.size(), 0);

        // Synchronous code with enable set behaves single buffered (R12)
        clear_irq();
        frame_mode = 2'b00; dbuf_en = 1'b1;
        send(8'h96, 1, 1'b0, 1'b0, 1'b0, "R12 sync 8bit");
        wait_ticks(4);
        chk(tx_irq == 1'b0, "R12 no early irq", tx_irq, 0);
        send(8'h42, 0, 1'b0, 1'b0, 1'b0, "R12");
        wait_ticks(12);
        chk(tx_irq == 1'b1, "R12 irq at end", tx_irq, 1);
        wait_ticks(4);
        chk(q.size() == 0, "R12 ignored write", q.size(), 0);

        // Flag holds without clear (R11)
        wait_ticks(5);
        chk(tx_irq == 1'b1, "R11 held", tx_irq, 1);
        clear_irq();
        chk(tx_irq == 1'b0, "R11 clear", tx_irq, 0);
        chk(txd == 1'b1, "R2 idle high", txd, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule